// File: doc/BRIEF.md
# Crypto DMA Engine Control and Interrupt Register Block

This block is the software-facing register file of a descriptor-driven crypto DMA engine. It holds the base addresses of the source and destination descriptor rings, the engine configuration and the interrupt enables. It also records engine events as sticky pending flags and combines the enabled flags into one registered interrupt line. Software writes the command word to start descriptor polling or to reset the engine. Each of these actions comes out as a one-cycle pulse that the engine core consumes.

The bus is a plain word-indexed interface. `bus_addr` selects one of four 32-bit words: 0 is the source ring base, 1 is the destination ring base, 2 is command/status, and 3 is control. A write completes in the cycle it is presented. A read returns its data on `bus_rdata` one cycle later, and that value is held until the next read.

Top module: `cxe_csr_top`

## Requirements
- R1: After reset, every register reads 0, `irq`, `poll_kick` and `soft_rst` are 0, and every configuration output is 0.
- R2: Words 0 and 1 store all 32 written bits. They read back unchanged and drive `src_ring_base` and `dst_ring_base` from the cycle after the write.
- R3: A one-cycle pulse on `evt_pulse[i]` sets pending flag i. The flag reads back in command word bit 11+i: bit 15 is source unavailable (i=4), bit 14 is source length error, bit 13 is destination unavailable, bit 12 is destination done, and bit 11 is the address-buffer event (i=0).
- R4: Writing 1 to a pending bit position in the command word clears that flag. Writing 0 there leaves the flag unchanged.
- R5: When an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R6: `irq` goes high one cycle after some pending flag i is set while control bit 11+i is 1. It falls one cycle after no enabled flag remains. A pending flag whose enable is 0 never raises `irq`.
- R7: Writing 1 to command bit 1 produces a single-cycle `poll_kick` in the cycle after the write. Command bits 1 and 0 always read as 0.
- R8: Writing 1 to command bit 0 produces a single-cycle `soft_rst` and clears all pending flags. The ring bases and the control word keep their values.
- R9: Control bit 8 drives `loopback_en`, bit 7 drives `inplace_wb_en` and bit 6 drives `eng_clk_en`. All three read back as written.
- R10: Control bits 5:3 hold the destination burst code and bits 2:0 hold the source burst code. Both read back raw. `dst_burst_sel` and `src_burst_sel` give the code, limited to 3 (0=16, 1=32, 2=64, 3=128 bytes), so codes 4 to 7 give 3.
- R11: `bus_rdata` is updated one cycle after `bus_rd`. Bits with no function read as 0: command bits 31:16 and 10:0, and control bits 31:16 and 10:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 5 | Engine event pulses, bit i maps to pending bit 11+i |
| irq | output | 1 | Registered interrupt request |
| poll_kick | output | 1 | One-cycle descriptor poll request |
| soft_rst | output | 1 | One-cycle engine reset request |
| src_ring_base | output | 32 | Source descriptor ring base |
| dst_ring_base | output | 32 | Destination descriptor ring base |
| loopback_en | output | 1 | Loopback mode |
| inplace_wb_en | output | 1 | Source-address writeback (in place) |
| eng_clk_en | output | 1 | Engine clock enable |
| dst_burst_sel | output | 2 | Limited destination burst code |
| src_burst_sel | output | 2 | Limited source burst code |

## Verification
Writes, event pulses and the poll and reset pulses take effect at the clock edge where they are sampled. Their results are visible at the following negative edge. `bus_rdata` is valid at the negative edge after the read edge, and `irq` lags the pending flags by one further edge. The bench drives every stimulus at a negative edge and steps exactly that many edges before it samples: it checks that `irq` is still low one edge after a flag appears and high on the next. It also checks that the poll and reset pulses are gone one cycle later.

// File: rtl/cxe_csr_pkg.sv
package cxe_csr_pkg;
    typedef enum logic [1:0] {
        RIX_SRC = 2'd0,
        RIX_DST = 2'd1,
        RIX_CMD = 2'd2,
        RIX_CTL = 2'd3
    } reg_ix_e;

    localparam int unsigned SRST_BIT = 0;
    localparam int unsigned POLL_BIT = 1;
    localparam int unsigned SBST_LO  = 0;
    localparam int unsigned DBST_LO  = 3;
    localparam int unsigned CKEN_BIT = 6;
    localparam int unsigned INPL_BIT = 7;
    localparam int unsigned LOOP_BIT = 8;
endpackage

// File: rtl/cxe_csr_cfg.sv
module cxe_csr_cfg
    import cxe_csr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_EVT = 5,
    parameter int unsigned EVT_LSB = 11,
    parameter int unsigned BST_W   = 3,
    parameter int unsigned SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_src,
    input  logic               wr_dst,
    input  logic               wr_ctl,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  src_base,
    output logic [DATA_W-1:0]  dst_base,
    output logic [NUM_EVT-1:0] ien,
    output logic               loop_en,
    output logic               inpl_en,
    output logic               cken,
    output logic [BST_W-1:0]   dst_code,
    output logic [BST_W-1:0]   src_code,
    output logic [SEL_W-1:0]   dst_sel,
    output logic [SEL_W-1:0]   src_sel
);
    localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
    localparam int unsigned NCH     = 2;

    typedef struct packed {
        logic [DATA_W-1:0]  src;
        logic [DATA_W-1:0]  dst;
        logic [NUM_EVT-1:0] ien;
        logic               loop;
        logic               inpl;
        logic               cken;
        logic [BST_W-1:0]   dbst;
        logic [BST_W-1:0]   sbst;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_src) cfg_d.src = wdata;
        if (wr_dst) cfg_d.dst = wdata;
        if (wr_ctl) begin
            cfg_d.ien  = wdata[EVT_LSB +: NUM_EVT];
            cfg_d.loop = wdata[LOOP_BIT];
            cfg_d.inpl = wdata[INPL_BIT];
            cfg_d.cken = wdata[CKEN_BIT];
            cfg_d.dbst = wdata[DBST_LO +: BST_W];
            cfg_d.sbst = wdata[SBST_LO +: BST_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // burst code limiter, one per DMA direction
    logic [NCH-1:0][BST_W-1:0] code_w;
    logic [NCH-1:0][SEL_W-1:0] sel_w;
    assign code_w[0] = cfg_q.sbst;
    assign code_w[1] = cfg_q.dbst;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_clamp
        always_comb begin
            if (int'(code_w[ch]) > int'(MAX_SEL)) sel_w[ch] = SEL_W'(MAX_SEL);
            else                                  sel_w[ch] = code_w[ch][SEL_W-1:0];
        end
    end

    assign src_base = cfg_q.src;
    assign dst_base = cfg_q.dst;
    assign ien      = cfg_q.ien;
    assign loop_en  = cfg_q.loop;
    assign inpl_en  = cfg_q.inpl;
    assign cken     = cfg_q.cken;
    assign dst_code = cfg_q.dbst;
    assign src_code = cfg_q.sbst;
    assign src_sel  = sel_w[0];
    assign dst_sel  = sel_w[1];

    assert_src_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_src |=> $stable(src_base));
    assert_dst_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dst |=> $stable(dst_base));
    assert_src_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_code) >= int'(MAX_SEL)) |-> (src_sel == SEL_W'(MAX_SEL)));
    assert_dst_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(dst_code) >= int'(MAX_SEL)) |-> (dst_sel == SEL_W'(MAX_SEL)));
    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> ($stable(src_sel) && $stable(dst_sel)));
endmodule

// File: rtl/cxe_csr_cmd.sv
module cxe_csr_cmd #(
    parameter int unsigned NUM_EVT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cmd,
    input  logic [NUM_EVT-1:0] w1c_bits,
    input  logic               poll_bit,
    input  logic               srst_bit,
    output logic [NUM_EVT-1:0] clr_mask,
    output logic               poll_kick,
    output logic               soft_rst
);
    typedef struct packed {
        logic poll;
        logic srst;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d      = '0;
        clr_mask   = '0;
        if (wr_cmd) begin
            cmd_d.poll = poll_bit;
            cmd_d.srst = srst_bit;
            clr_mask   = w1c_bits | {NUM_EVT{srst_bit}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign poll_kick = cmd_q.poll;
    assign soft_rst  = cmd_q.srst;

    assert_poll_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_kick |-> $past(wr_cmd && poll_bit));
    assert_srst_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(wr_cmd && srst_bit));
endmodule

// File: rtl/cxe_csr_pend.sv
module cxe_csr_pend #(
    parameter int unsigned NUM_EVT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] clr,
    input  logic [NUM_EVT-1:0] ien,
    output logic [NUM_EVT-1:0] pend,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_EVT-1:0] pend;
        logic               irq;
    } pnd_t;

    pnd_t pnd_d, pnd_q;

    always_comb begin
        pnd_d      = pnd_q;
        pnd_d.pend = (pnd_q.pend & ~clr) | evt;
        pnd_d.irq  = |(pnd_q.pend & ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pnd_q <= '0;
        else        pnd_q <= pnd_d;
    end

    assign pend = pnd_q.pend;
    assign irq  = pnd_q.irq;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
        assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend[i]);
        assert_clr_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !pend[i]);
        assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);
    end

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(pend & ien)));
endmodule

// File: rtl/cxe_csr_top.sv
module cxe_csr_top
    import cxe_csr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_EVT = 5,
    parameter int unsigned EVT_LSB = 11,
    parameter int unsigned BST_W   = 3,
    parameter int unsigned SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq,
    output logic               poll_kick,
    output logic               soft_rst,
    output logic [DATA_W-1:0]  src_ring_base,
    output logic [DATA_W-1:0]  dst_ring_base,
    output logic               loopback_en,
    output logic               inplace_wb_en,
    output logic               eng_clk_en,
    output logic [SEL_W-1:0]   dst_burst_sel,
    output logic [SEL_W-1:0]   src_burst_sel
);
    logic wr_src, wr_dst, wr_cmd, wr_ctl;
    logic [NUM_EVT-1:0] ien, pend, clr_mask;
    logic [BST_W-1:0]   dst_code, src_code;

    assign wr_src = bus_wr && (bus_addr == RIX_SRC);
    assign wr_dst = bus_wr && (bus_addr == RIX_DST);
    assign wr_cmd = bus_wr && (bus_addr == RIX_CMD);
    assign wr_ctl = bus_wr && (bus_addr == RIX_CTL);

    cxe_csr_cfg #(
        .DATA_W (DATA_W), .NUM_EVT(NUM_EVT), .EVT_LSB(EVT_LSB),
        .BST_W  (BST_W),  .SEL_W  (SEL_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_src   (wr_src),
        .wr_dst   (wr_dst),
        .wr_ctl   (wr_ctl),
        .wdata    (bus_wdata),
        .src_base (src_ring_base),
        .dst_base (dst_ring_base),
        .ien      (ien),
        .loop_en  (loopback_en),
        .inpl_en  (inplace_wb_en),
        .cken     (eng_clk_en),
        .dst_code (dst_code),
        .src_code (src_code),
        .dst_sel  (dst_burst_sel),
        .src_sel  (src_burst_sel)
    );

    cxe_csr_cmd #(.NUM_EVT(NUM_EVT)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_cmd),
        .w1c_bits  (bus_wdata[EVT_LSB +: NUM_EVT]),
        .poll_bit  (bus_wdata[POLL_BIT]),
        .srst_bit  (bus_wdata[SRST_BIT]),
        .clr_mask  (clr_mask),
        .poll_kick (poll_kick),
        .soft_rst  (soft_rst)
    );

    cxe_csr_pend #(.NUM_EVT(NUM_EVT)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_pulse),
        .clr   (clr_mask),
        .ien   (ien),
        .pend  (pend),
        .irq   (irq)
    );

    // read path
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            RIX_SRC: rd_mux = src_ring_base;
            RIX_DST: rd_mux = dst_ring_base;
            RIX_CMD: rd_mux[EVT_LSB +: NUM_EVT] = pend;
            RIX_CTL: begin
                rd_mux[EVT_LSB +: NUM_EVT] = ien;
                rd_mux[LOOP_BIT]           = loopback_en;
                rd_mux[INPL_BIT]           = inplace_wb_en;
                rd_mux[CKEN_BIT]           = eng_clk_en;
                rd_mux[DBST_LO +: BST_W]   = dst_code;
                rd_mux[SBST_LO +: BST_W]   = src_code;
            end
            default: rd_mux = '0;
        endcase
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> ((pend & ~$past(evt_pulse)) == '0));
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    assert_kick_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({poll_kick, soft_rst}) || $past(wr_cmd));
endmodule

// File: tb/cxe_csr_top_tb.sv
`timescale 1ns/1ps
module cxe_csr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  evt_pulse = '0;
    logic        irq, poll_kick, soft_rst;
    logic [31:0] src_ring_base, dst_ring_base;
    logic        loopback_en, inplace_wb_en, eng_clk_en;
    logic [1:0]  dst_burst_sel, src_burst_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cxe_csr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq(irq), .poll_kick(poll_kick),
        .soft_rst(soft_rst), .src_ring_base(src_ring_base),
        .dst_ring_base(dst_ring_base), .loopback_en(loopback_en),
        .inplace_wb_en(inplace_wb_en), .eng_clk_en(eng_clk_en),
        .dst_burst_sel(dst_burst_sel), .src_burst_sel(src_burst_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        evt_pulse = e;
        step();
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg zero", v, 32'h0);
        end
        chk("R1 outputs", {irq, poll_kick, soft_rst, loopback_en, inplace_wb_en,
                           eng_clk_en, dst_burst_sel, src_burst_sel}, 32'h0);
        chk("R1 src base", src_ring_base, 32'h0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        wr(2'd0, 32'hDEAD_BEEC);
        wr(2'd1, 32'h1234_5678);
        chk("R2 src out", src_ring_base, 32'hDEAD_BEEC);
        chk("R2 dst out", dst_ring_base, 32'h1234_5678);
        rd(2'd0, v); chk("R2 src read", v, 32'hDEAD_BEEC);
        rd(2'd1, v); chk("R2 dst read", v, 32'h1234_5678);
        step();
        chk("R11 rdata held", bus_rdata, 32'h1234_5678);
    endtask

    task automatic t_pend_clear();
        logic [31:0] v;
        pulse(5'b10100);
        rd(2'd2, v); chk("R3 pend bits 15,13", v, 32'h0000_A000);
        chk("R6 masked no irq", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_2000);
        rd(2'd2, v); chk("R4 w1c bit13", v, 32'h0000_8000);
        wr(2'd2, 32'h0000_0000);
        rd(2'd2, v); chk("R4 write0 keeps", v, 32'h0000_8000);
        wr(2'd2, 32'h0000_8000);
        rd(2'd2, v); chk("R4 w1c bit15", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        evt_pulse = 5'b00001;
        wr(2'd2, 32'h0000_0800);
        evt_pulse = '0;
        rd(2'd2, v); chk("R5 set wins", v, 32'h0000_0800);
        wr(2'd2, 32'h0000_0800);
        rd(2'd2, v); chk("R5 later clear", v, 32'h0);
    endtask

    task automatic t_irq();
        wr(2'd3, 32'h0000_1000);
        pulse(5'b00001);
        step(); step();
        chk("R6 other bit masked", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_0800);
        pulse(5'b00010);
        chk("R6 irq latency lo", {31'b0, irq}, 32'h0);
        step();
        chk("R6 irq high", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0000_1000);
        chk("R6 irq still high", {31'b0, irq}, 32'h1);
        step();
        chk("R6 irq falls", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_poll();
        logic [31:0] v;
        wr(2'd2, 32'h0000_0002);
        chk("R7 poll pulse", {30'b0, poll_kick, soft_rst}, 32'h2);
        step();
        chk("R7 poll ends", {31'b0, poll_kick}, 32'h0);
        rd(2'd2, v); chk("R7 reads 0", v, 32'h0);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        wr(2'd3, 32'h0000_F9D1);
        pulse(5'b11111);
        rd(2'd2, v); chk("R3 all pend", v, 32'h0000_F800);
        wr(2'd2, 32'h0000_0001);
        chk("R8 srst pulse", {30'b0, poll_kick, soft_rst}, 32'h1);
        step();
        chk("R8 srst ends", {31'b0, soft_rst}, 32'h0);
        rd(2'd2, v); chk("R8 pend cleared", v, 32'h0);
        rd(2'd0, v); chk("R8 base kept", v, 32'hDEAD_BEEC);
        rd(2'd3, v); chk("R8 ctrl kept", v, 32'h0000_F9D1);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(2'd3, 32'h0000_01D1);
        chk("R9 flags", {29'b0, loopback_en, inplace_wb_en, eng_clk_en}, 32'h7);
        chk("R10 sel 2/1", {28'b0, dst_burst_sel, src_burst_sel}, 32'h9);
        rd(2'd3, v); chk("R9 readback", v, 32'h0000_01D1);
        wr(2'd3, 32'h0000_0140);
        chk("R9 loop+clk only", {29'b0, loopback_en, inplace_wb_en, eng_clk_en}, 32'h5);
        wr(2'd3, 32'h0000_003F);
        chk("R10 sel 7/7 limited", {28'b0, dst_burst_sel, src_burst_sel}, 32'hF);
        rd(2'd3, v); chk("R10 raw readback", v, 32'h0000_003F);
        wr(2'd3, 32'h0000_0020);
        chk("R10 dst 4 limited", {28'b0, dst_burst_sel, src_burst_sel}, 32'hC);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R11 ctrl unused zero", v, 32'h0000_F9FF);
        wr(2'd3, 32'h0);
        pulse(5'b11111);
        bus_wdata = 32'hFFFF_07FC;
        rd(2'd2, v); chk("R11 cmd unused zero", v, 32'h0000_F800);
        wr(2'd2, 32'h0000_F800);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base();
        t_pend_clear();
        t_set_wins();
        t_irq();
        t_poll();
        t_srst();
        t_ctrl();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule